// File: doc/BRIEF.md
# Segment Descriptor Access Checker

This block holds one 8-byte segment descriptor in a cached register and screens every memory access made through that segment. A load port accepts the descriptor as a 64-bit word. Descriptors that cannot be used are refused when they are loaded. Each accepted descriptor replaces the cached copy, and from then on every access is checked against it.

An access gives an offset, a kind (read, write or execute), the current and requested privilege levels and a size in bytes. One cycle later the block returns either the linear address (base plus offset) or a fault code. The first access that succeeds on a descriptor whose accessed flag is clear sets that flag in the cached copy. On that same cycle the block raises a one-cycle request to write the updated descriptor back to memory.

The limit bound depends on three flags. Granularity scales it to 4096-byte units. Expand-down data segments invert it. The B flag picks a 16-bit or 32-bit ceiling.

Top module: `seg_access_checker`

## Requirements
- R1: A successful access returns `rsp_linear` = base + offset modulo 2^32. The base is assembled from descriptor bits 63:56 (base 31:24), 39:32 (base 23:16) and 31:16 (base 15:0). A faulted access returns `rsp_linear` = 0.
- R2: The 20-bit limit is descriptor bits 51:48 (upper) and 15:0 (lower). When bit 55 (granularity) is clear, the effective limit is that value in bytes. When bit 55 is set, the effective limit is (limit << 12) | 0xFFF.
- R3: Fault codes on `rsp_fault` are 0 none, 1 no descriptor, 2 not present, 3 protection, 4 privilege, 5 limit. When several apply, the first in that order is reported. In particular, a clear present flag (bit 47) gives code 2 whatever the limit and kind.
- R4: For an expand-up segment, the last byte (offset + size − 1) must not exceed the effective limit. A size of 0 counts as 1. A last-byte computation that carries past 2^32 − 1 is a limit fault.
- R5: A data segment (bit 43 clear) with bit 42 set expands down. Its valid offsets run from effective limit + 1 up to the maximum offset, checked on both the first and the last byte.
- R6: The maximum offset is 0xFFFFFFFF when bit 54 (B) is set and 0x0000FFFF when it is clear. The last byte must not exceed it, whether the segment expands up or down.
- R7: `acc_kind` is 0 read, 1 write, 2 execute, 3 reserved. Each of the following gives code 3: a write to data with bit 41 clear, a read of code with bit 41 clear, an execute of data, a write to code, and kind 3. Execute of code is allowed whatever bit 41 holds.
- R8: Bits 46:45 hold the DPL. The access must satisfy max(`acc_cpl`, `acc_rpl`) ≤ DPL, or it gets code 4. Conforming code (bits 43 and 42 both set) skips this check.
- R9: A load is refused when bits 53 and 54 are both set, or when bit 44 is clear. A refused load pulses `load_err` for one cycle and leaves no valid descriptor.
- R10: The first successful access while the cached bit 40 is clear pulses `wb_req` with the response. It presents `wb_desc` as the cached descriptor with bit 40 set, and later accesses do not pulse it again. A descriptor loaded with bit 40 already set never pulses it.
- R11: After reset or a refused load, every access returns code 1.
- R12: `rsp_valid` is high exactly in the cycle after a cycle with `acc_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Load `load_desc` into the cache |
| load_desc | input | 64 | Descriptor word to load |
| load_err | output | 1 | One-cycle pulse: last load refused |
| acc_valid | input | 1 | Access request |
| acc_offset | input | 32 | Offset into the segment |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| acc_cpl | input | 2 | Current privilege level |
| acc_rpl | input | 2 | Requested privilege level |
| acc_size | input | 3 | Access size in bytes (0 counts as 1) |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 3 | Fault code |
| rsp_linear | output | 32 | Linear address, 0 on fault |
| wb_req | output | 1 | One-cycle accessed-flag write-back request |
| wb_desc | output | 64 | Descriptor to write back |

## Verification
The assertions check the following on every cycle:
- the one-cycle response timing;
- that a write-back request only comes with a fault-free response and carries the accessed bit;
- that a refused load is flagged;
- that the limit checker never passes a wrapped last byte;
- that the permission checker never lets execute reach a data segment.

Only the bench scenarios can show the rest. That covers the exact field assembly of base and limit, granularity scaling, the expand-down window under both ceilings, the fault priority, the privilege and conforming rules, and the single write-back per descriptor.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    localparam int DESC_W     = 64;
    localparam int LIMIT_W    = 20;
    localparam int PAGE_SHIFT = 12;
    localparam int OFS_W      = LIMIT_W + PAGE_SHIFT;
    localparam int SIZE_W     = 3;

    typedef enum logic [2:0] {
        F_NONE    = 3'd0,
        F_NO_DESC = 3'd1,
        F_NOT_PRS = 3'd2,
        F_PROT    = 3'd3,
        F_PRIV    = 3'd4,
        F_LIMIT   = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_WRITE = 2'd1,
        K_EXEC  = 2'd2,
        K_RSVD  = 2'd3
    } kind_e;

    typedef struct packed {
        logic [OFS_W-1:0]   base;
        logic [LIMIT_W-1:0] limit;
        logic               gran;
        logic               big;
        logic               present;
        logic [1:0]         dpl;
        logic               is_code;
        logic               conf_or_down;
        logic               rd_or_wr;
        logic               accessed;
    } desc_fields_t;

endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
    import seg_chk_pkg::*;
(
    input  logic [DESC_W-1:0] raw,
    output desc_fields_t      fld
);
    always_comb begin
        fld.base         = {raw[63:56], raw[39:32], raw[31:16]};
        fld.limit        = {raw[51:48], raw[15:0]};
        fld.gran         = raw[55];
        fld.big          = raw[54];
        fld.present      = raw[47];
        fld.dpl          = raw[46:45];
        fld.is_code      = raw[43];
        fld.conf_or_down = raw[42];
        fld.rd_or_wr     = raw[41];
        fld.accessed     = raw[40];
    end
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check #(
    parameter int LIM_W  = 20,
    parameter int PG_SH  = 12,
    parameter int SZ_W   = 3
) (
    input  logic [LIM_W-1:0]       limit,
    input  logic                   gran,
    input  logic                   expand_down,
    input  logic                   big,
    input  logic [LIM_W+PG_SH-1:0] offset,
    input  logic [SZ_W-1:0]        size,
    output logic                   in_range
);
    localparam int AW = LIM_W + PG_SH;

    logic [AW-1:0] eff_lim;
    logic [AW-1:0] max_ofs;
    logic [AW-1:0] span;
    logic [AW:0]   last;
    logic          carry;
    logic          over_max;

    always_comb begin
        eff_lim  = gran ? {limit, {PG_SH{1'b1}}} : {{PG_SH{1'b0}}, limit};
        max_ofs  = big ? {AW{1'b1}} : {{(AW-16){1'b0}}, 16'hFFFF};
        span     = (size == '0) ? '0 : AW'(size - 1'b1);
        last     = {1'b0, offset} + {1'b0, span};
        carry    = last[AW];
        over_max = last[AW-1:0] > max_ofs;
        if (carry || over_max)
            in_range = 1'b0;
        else if (expand_down)
            in_range = offset > eff_lim;
        else
            in_range = last[AW-1:0] <= eff_lim;
    end

    always_comb begin
        if (in_range)
            assert_no_wrap_R4: assert ({1'b0, offset} + {1'b0, span} <= {1'b0, {AW{1'b1}}});
    end
endmodule

// File: rtl/seg_perm_check.sv
module seg_perm_check
    import seg_chk_pkg::*;
(
    input  logic       is_code,
    input  logic       conf_or_down,
    input  logic       rd_or_wr,
    input  logic [1:0] dpl,
    input  logic [1:0] kind,
    input  logic [1:0] cpl,
    input  logic [1:0] rpl,
    output logic       kind_ok,
    output logic       priv_ok
);
    logic [1:0] eff_pl;

    always_comb begin
        unique case (kind_e'(kind))
            K_READ:  kind_ok = is_code ? rd_or_wr : 1'b1;
            K_WRITE: kind_ok = is_code ? 1'b0 : rd_or_wr;
            K_EXEC:  kind_ok = is_code;
            default: kind_ok = 1'b0;
        endcase
        eff_pl  = (cpl > rpl) ? cpl : rpl;
        priv_ok = (is_code && conf_or_down) || (eff_pl <= dpl);
    end

    always_comb begin
        if (!is_code && kind == 2'd2)
            assert_no_exec_data_R7: assert (!kind_ok);
    end
endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker
    import seg_chk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [DESC_W-1:0] load_desc,
    output logic              load_err,
    input  logic              acc_valid,
    input  logic [OFS_W-1:0]  acc_offset,
    input  logic [1:0]        acc_kind,
    input  logic [1:0]        acc_cpl,
    input  logic [1:0]        acc_rpl,
    input  logic [SIZE_W-1:0] acc_size,
    output logic              rsp_valid,
    output logic [2:0]        rsp_fault,
    output logic [OFS_W-1:0]  rsp_linear,
    output logic              wb_req,
    output logic [DESC_W-1:0] wb_desc
);
    localparam int ACC_BIT = 40;

    typedef struct packed {
        logic [DESC_W-1:0] raw;
        logic              valid;
        logic              load_err;
        logic              rsp_valid;
        fault_e            rsp_fault;
        logic [OFS_W-1:0]  rsp_linear;
        logic              wb_req;
        logic [DESC_W-1:0] wb_desc;
    } state_t;

    state_t       st_d, st_q;
    desc_fields_t fld;
    logic         in_range_w;
    logic         kind_ok_w;
    logic         priv_ok_w;
    logic         load_bad;
    fault_e       fault_w;

    seg_desc_decode u_decode (
        .raw (st_q.raw),
        .fld (fld)
    );

    seg_limit_check #(
        .LIM_W (LIMIT_W),
        .PG_SH (PAGE_SHIFT),
        .SZ_W  (SIZE_W)
    ) u_limit (
        .limit       (fld.limit),
        .gran        (fld.gran),
        .expand_down (!fld.is_code && fld.conf_or_down),
        .big         (fld.big),
        .offset      (acc_offset),
        .size        (acc_size),
        .in_range    (in_range_w)
    );

    seg_perm_check u_perm (
        .is_code      (fld.is_code),
        .conf_or_down (fld.conf_or_down),
        .rd_or_wr     (fld.rd_or_wr),
        .dpl          (fld.dpl),
        .kind         (acc_kind),
        .cpl          (acc_cpl),
        .rpl          (acc_rpl),
        .kind_ok      (kind_ok_w),
        .priv_ok      (priv_ok_w)
    );

    always_comb begin
        load_bad = (load_desc[53] && load_desc[54]) || !load_desc[44];

        if (!st_q.valid)        fault_w = F_NO_DESC;
        else if (!fld.present)  fault_w = F_NOT_PRS;
        else if (!kind_ok_w)    fault_w = F_PROT;
        else if (!priv_ok_w)    fault_w = F_PRIV;
        else if (!in_range_w)   fault_w = F_LIMIT;
        else                    fault_w = F_NONE;

        st_d            = st_q;
        st_d.rsp_valid  = 1'b0;
        st_d.rsp_fault  = F_NONE;
        st_d.rsp_linear = '0;
        st_d.wb_req     = 1'b0;
        st_d.load_err   = 1'b0;

        if (acc_valid) begin
            st_d.rsp_valid = 1'b1;
            st_d.rsp_fault = fault_w;
            if (fault_w == F_NONE) begin
                st_d.rsp_linear = fld.base + acc_offset;
                if (!fld.accessed) begin
                    st_d.raw[ACC_BIT] = 1'b1;
                    st_d.wb_req       = 1'b1;
                    st_d.wb_desc      = st_d.raw;
                end
            end
        end

        if (load_valid) begin
            if (load_bad) begin
                st_d.valid    = 1'b0;
                st_d.load_err = 1'b1;
            end else begin
                st_d.valid = 1'b1;
                st_d.raw   = load_desc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{raw: '0, valid: 1'b0, load_err: 1'b0, rsp_valid: 1'b0,
                      rsp_fault: F_NONE, rsp_linear: '0, wb_req: 1'b0, wb_desc: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign load_err   = st_q.load_err;
    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_fault  = st_q.rsp_fault;
    assign rsp_linear = st_q.rsp_linear;
    assign wb_req     = st_q.wb_req;
    assign wb_desc    = st_q.wb_desc;

    assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);
    assert_rsp_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);
    assert_wb_on_success_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (rsp_valid && rsp_fault == F_NONE && wb_desc[ACC_BIT]));
    assert_bad_load_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && load_desc[53] && load_desc[54]) |=> load_err);
    assert_no_desc_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && load_err) |=> (rsp_fault == F_NO_DESC));
endmodule

// File: tb/seg_access_checker_tb.sv
module seg_access_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_valid = 1'b0;
    logic [63:0] load_desc = '0;
    logic        load_err;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_offset = '0;
    logic [1:0]  acc_kind = '0;
    logic [1:0]  acc_cpl = '0;
    logic [1:0]  acc_rpl = '0;
    logic [2:0]  acc_size = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_fault;
    logic [31:0] rsp_linear;
    logic        wb_req;
    logic [63:0] wb_desc;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct packed {
        logic [2:0]  fault;
        logic [31:0] lin;
        logic        wb;
        logic [63:0] wdesc;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    seg_access_checker dut_i (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_desc(load_desc),
        .load_err(load_err), .acc_valid(acc_valid), .acc_offset(acc_offset),
        .acc_kind(acc_kind), .acc_cpl(acc_cpl), .acc_rpl(acc_rpl), .acc_size(acc_size),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_linear(rsp_linear),
        .wb_req(wb_req), .wb_desc(wb_desc)
    );

    function automatic logic [63:0] mk_desc(
        input logic [31:0] base, input logic [19:0] lim, input logic g, input logic db,
        input logic l, input logic p, input logic [1:0] dpl, input logic s,
        input logic code, input logic ce, input logic rw, input logic a);
        logic [63:0] d;
        d = '0;
        d[15:0]  = lim[15:0];
        d[51:48] = lim[19:16];
        d[31:16] = base[15:0];
        d[39:32] = base[23:16];
        d[63:56] = base[31:24];
        d[40] = a;  d[41] = rw; d[42] = ce; d[43] = code; d[44] = s;
        d[46:45] = dpl; d[47] = p; d[53] = l; d[54] = db; d[55] = g;
        return d;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [63:0] d, input logic exp_err, input string tag);
        @(negedge clk);
        load_valid = 1'b1;
        load_desc  = d;
        @(negedge clk);
        load_valid = 1'b0;
        check(tag, {63'd0, load_err}, {63'd0, exp_err});
    endtask

    task automatic do_acc(input logic [31:0] ofs, input logic [1:0] kind, input logic [1:0] cpl,
                          input logic [1:0] rpl, input logic [2:0] sz, input logic [2:0] ef,
                          input logic [31:0] el, input logic ewb, input logic [63:0] ewd,
                          input string tag);
        exp_t e;
        @(negedge clk);
        acc_valid  = 1'b1;
        acc_offset = ofs;
        acc_kind   = kind;
        acc_cpl    = cpl;
        acc_rpl    = rpl;
        acc_size   = sz;
        e.fault = ef; e.lin = el; e.wb = ewb; e.wdesc = ewd;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // Monitor: pops one expected item per response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12 unexpected response actual=1 expected=0");
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " fault"}, {61'd0, rsp_fault}, {61'd0, e.fault});
                check({t, " linear"}, {32'd0, rsp_linear}, {32'd0, e.lin});
                check({t, " wb_req"}, {63'd0, wb_req}, {63'd0, e.wb});
                if (e.wb) check({t, " wb_desc"}, wb_desc, e.wdesc);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] da, db_, dc, dd, de, df, dg, dh;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check("reset wb_req", {63'd0, wb_req}, 64'd0);
        check("reset load_err", {63'd0, load_err}, 64'd0);

        // R11: nothing loaded after reset
        do_acc(32'h0, 2'd0, 2'd0, 2'd0, 3'd1, 3'd1, 32'h0, 1'b0, 64'h0, "R11 after reset");

        // A: data RW, byte granular, limit 0xFFF, base 0x12345678
        da = mk_desc(32'h12345678, 20'h00FFF, 0, 1, 0, 1, 2'd3, 1, 0, 0, 1, 0);
        do_load(da, 1'b0, "R9 good load A");
        do_acc(32'h10, 2'd0, 2'd0, 2'd0, 3'd4, 3'd0, 32'h12345688, 1'b1, da | 64'h100_0000_0000, "R1 R10 first read");
        do_acc(32'h20, 2'd1, 2'd0, 2'd0, 3'd4, 3'd0, 32'h12345698, 1'b0, 64'h0, "R10 no second wb");
        do_acc(32'hFFD, 2'd0, 2'd0, 2'd0, 3'd4, 3'd5, 32'h0, 1'b0, 64'h0, "R4 last byte over");
        do_acc(32'hFFC, 2'd0, 2'd0, 2'd0, 3'd4, 3'd0, 32'h12346674, 1'b0, 64'h0, "R4 last byte at limit");
        do_acc(32'hFFF, 2'd0, 2'd0, 2'd0, 3'd0, 3'd0, 32'h12346677, 1'b0, 64'h0, "R4 size zero as one");
        do_acc(32'h0, 2'd2, 2'd0, 2'd0, 3'd1, 3'd3, 32'h0, 1'b0, 64'h0, "R7 exec data");
        do_acc(32'h0, 2'd3, 2'd0, 2'd0, 3'd1, 3'd3, 32'h0, 1'b0, 64'h0, "R7 reserved kind");

        // B: data read-only, page granular, limit 1 -> 0x1FFF, dpl 0
        db_ = mk_desc(32'hFF000000, 20'h00001, 1, 1, 0, 1, 2'd0, 1, 0, 0, 0, 1);
        do_load(db_, 1'b0, "R9 good load B");
        do_acc(32'h0, 2'd1, 2'd0, 2'd0, 3'd1, 3'd3, 32'h0, 1'b0, 64'h0, "R7 write read-only");
        do_acc(32'h1FFF, 2'd0, 2'd0, 2'd0, 3'd1, 3'd0, 32'hFF001FFF, 1'b0, 64'h0, "R2 page limit top");
        do_acc(32'h2000, 2'd0, 2'd0, 2'd0, 3'd1, 3'd5, 32'h0, 1'b0, 64'h0, "R2 page limit over");
        do_acc(32'h0, 2'd0, 2'd1, 2'd0, 3'd1, 3'd4, 32'h0, 1'b0, 64'h0, "R8 cpl above dpl");
        do_acc(32'h0, 2'd0, 2'd0, 2'd2, 3'd1, 3'd4, 32'h0, 1'b0, 64'h0, "R8 rpl above dpl");

        // C: flat 4 GiB, accessed preset
        dc = mk_desc(32'h0, 20'hFFFFF, 1, 1, 0, 1, 2'd3, 1, 0, 0, 1, 1);
        do_load(dc, 1'b0, "R9 good load C");
        do_acc(32'hFFFFFFFC, 2'd1, 2'd3, 2'd3, 3'd4, 3'd0, 32'hFFFFFFFC, 1'b0, 64'h0, "R10 preset no wb");
        do_acc(32'hFFFFFFFE, 2'd0, 2'd3, 2'd3, 3'd4, 3'd5, 32'h0, 1'b0, 64'h0, "R4 wrap");

        // D: expand-down, B clear, limit 0xFF, base 0x1000
        dd = mk_desc(32'h1000, 20'h000FF, 0, 0, 0, 1, 2'd3, 1, 0, 1, 1, 1);
        do_load(dd, 1'b0, "R9 good load D");
        do_acc(32'h80, 2'd0, 2'd0, 2'd0, 3'd1, 3'd5, 32'h0, 1'b0, 64'h0, "R5 below window");
        do_acc(32'hFF, 2'd0, 2'd0, 2'd0, 3'd1, 3'd5, 32'h0, 1'b0, 64'h0, "R5 at limit");
        do_acc(32'h100, 2'd0, 2'd0, 2'd0, 3'd2, 3'd0, 32'h1100, 1'b0, 64'h0, "R5 window start");
        do_acc(32'hFFFE, 2'd1, 2'd0, 2'd0, 3'd2, 3'd0, 32'h10FFE, 1'b0, 64'h0, "R6 16-bit top");
        do_acc(32'hFFFF, 2'd1, 2'd0, 2'd0, 3'd2, 3'd5, 32'h0, 1'b0, 64'h0, "R6 16-bit over");

        // E: expand-up, B clear, page granular
        de = mk_desc(32'h0, 20'hFFFFF, 1, 0, 0, 1, 2'd3, 1, 0, 0, 1, 1);
        do_load(de, 1'b0, "R9 good load E");
        do_acc(32'h10000, 2'd0, 2'd0, 2'd0, 3'd1, 3'd5, 32'h0, 1'b0, 64'h0, "R6 expand-up 16-bit");

        // F: conforming execute-only code, dpl 0
        df = mk_desc(32'h40000000, 20'h0FFFF, 0, 1, 0, 1, 2'd0, 1, 1, 1, 0, 0);
        do_load(df, 1'b0, "R9 good load F");
        do_acc(32'h10, 2'd0, 2'd3, 2'd3, 3'd1, 3'd3, 32'h0, 1'b0, 64'h0, "R7 read exec-only");
        do_acc(32'h10, 2'd2, 2'd3, 2'd3, 3'd1, 3'd0, 32'h40000010, 1'b1, df | 64'h100_0000_0000, "R8 conforming exec");
        do_acc(32'h10, 2'd1, 2'd0, 2'd0, 3'd1, 3'd3, 32'h0, 1'b0, 64'h0, "R7 write code");

        // G: non-conforming readable code, dpl 1
        dg = mk_desc(32'h00100000, 20'h0FFFF, 0, 1, 0, 1, 2'd1, 1, 1, 0, 1, 1);
        do_load(dg, 1'b0, "R9 good load G");
        do_acc(32'h4, 2'd2, 2'd2, 2'd0, 3'd1, 3'd4, 32'h0, 1'b0, 64'h0, "R8 non-conforming");
        do_acc(32'h4, 2'd0, 2'd1, 2'd1, 3'd4, 3'd0, 32'h00100004, 1'b0, 64'h0, "R7 read readable code");

        // H: not present, offset beyond limit and bad kind
        dh = mk_desc(32'h0, 20'h00001, 0, 1, 0, 0, 2'd0, 1, 0, 0, 0, 0);
        do_load(dh, 1'b0, "R9 good load H");
        do_acc(32'h5000, 2'd1, 2'd3, 2'd3, 3'd4, 3'd2, 32'h0, 1'b0, 64'h0, "R3 not present first");

        // R9 / R11: refused loads
        do_load(mk_desc(32'h0, 20'hFFFFF, 1, 1, 1, 1, 2'd0, 1, 1, 0, 1, 0), 1'b1, "R9 long and default");
        do_acc(32'h0, 2'd2, 2'd0, 2'd0, 3'd1, 3'd1, 32'h0, 1'b0, 64'h0, "R11 after refused load");
        do_load(da, 1'b0, "R9 reload A");
        do_load(mk_desc(32'h0, 20'hFFFFF, 1, 1, 0, 1, 2'd0, 0, 0, 0, 1, 0), 1'b1, "R9 system type");
        do_acc(32'h0, 2'd0, 2'd0, 2'd0, 3'd1, 3'd1, 32'h0, 1'b0, 64'h0, "R11 after system load");

        repeat (3) @(negedge clk);
        check("R12 all responses seen", {32'd0, exp_q.size()}, 64'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule